// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records when edges occur on a set of pins. Each pin is either driven by a PWM generator or used as a capture input. A 16-bit down counter is shared by all channels and steps once per prescaled clock period. When a channel is in capture mode, its pin passes through a synchronizer. A rising edge then copies the counter into that channel's rising latch, and a falling edge copies it into a separate falling latch. Either capture sets the channel's flag. Software clears a flag by writing a one to it.

Software reads the two latches of a channel, subtracts one from the other, and gets the high or low time of the signal in counter ticks. An edge that arrives before software has finished reading may replace a latch value. For this reason the time software needs to service a capture sets the highest input frequency the unit can measure. The interrupt line is raised by any flag whose interrupt enable bit is set.

Top module: `cap_latch_unit`

## Requirements
- R1: After reset the unit is in this state. All latches read 0. The flag register reads 0. irq is 0. Every channel is in PWM mode, so pad_oe is all ones. The counter starts at all ones.
- R2: Bit 4c of the control register (offset 0) selects the mode of channel c. With the bit at 0, the channel is in PWM mode: pad_out[c] follows pwm_in[c], pad_oe[c] is 1, and edges on pad_in[c] are ignored. With the bit at 1, the channel is in capture mode: pad_oe[c] is 0 and pad_out[c] is 0.
- R3: The counter decrements once every P+1 clocks. P is the prescale value at offset 1. The counter wraps from 0 to all ones.
- R4: In capture mode, a rising edge on pad_in[c] copies the counter into the rising latch at offset 4+2c. A falling edge copies it into the falling latch at offset 5+2c. The capture takes effect on the third clock edge after the pin changes. The difference between the two latches therefore equals the number of counter steps between the two edges.
- R5: Bit 4c+1 of the control register enables rising captures and bit 4c+2 enables falling captures. An edge of a disabled polarity leaves both the latch and the flag unchanged.
- R6: Every enabled capture sets the flag of channel c, which is bit c of the flag register at offset 2.
- R7: Writing offset 2 clears each flag whose data bit is 1. A data bit of 0 leaves its flag unchanged.
- R8: If a capture and a clearing write reach the same flag on the same clock edge, the flag stays set.
- R9: irq is 1 exactly when some channel has its flag set and its interrupt enable bit 4c+3 set.
- R10: A later capture replaces the value in a latch even when the flag is still set.
- R11: A capture on one channel changes no other channel's latches or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, combinational from reg_addr |
| pwm_in | input | NCH | PWM generator outputs, one per channel |
| pad_in | input | NCH | Pin input values |
| pad_out | output | NCH | Pin output values |
| pad_oe | output | NCH | Pin output enables |
| irq | output | 1 | Capture interrupt request |

## Verification
A pin change becomes a capture on the third rising clock edge. The bench checks this by reading irq after the second edge, when it must still be 0, and after the third edge, when it must be 1. Latch contents are compared only as differences between two captures. Those differences come from gaps the bench chooses. With prescale values above zero, each gap is a whole multiple of the prescale period, so the expected difference does not depend on the prescaler's phase. Register writes take effect on the clock edge that follows the write strobe. Reads are taken one time step after a falling edge, once the combinational read path has settled. The collision test places the write strobe on exactly the same edge as the capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
   // bit positions inside each channel's control nibble
   localparam int CTL_MODE = 0;
   localparam int CTL_RISE = 1;
   localparam int CTL_FALL = 2;
   localparam int CTL_IE   = 3;
   localparam int CTL_BITS = 4;

   // register word offsets
   localparam int OFS_CTRL  = 0;
   localparam int OFS_PRESC = 1;
   localparam int OFS_FLAG  = 2;
   localparam int OFS_LATCH = 4;

   typedef struct packed {
      logic irq_en;
      logic fall_en;
      logic rise_en;
      logic cap_mode;
   } chan_cfg_t;
endpackage

// File: rtl/cap_timebase.sv
module cap_timebase #(
   parameter int CNT_W = 16,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] presc,
   output logic [CNT_W-1:0] count
);
   logic [PRE_W-1:0] div_q;
   logic             tick;

   assign tick = (div_q >= presc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         count <= '1;
      end else begin
         div_q <= tick ? '0 : div_q + 1'b1;
         if (tick) count <= count - 1'b1;
      end
   end

   p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> count == CNT_W'($past(count) - 1'b1));
   p_count_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));
endmodule

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sh_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[SYNC_STAGES-2:0], pin};
         prev_q <= sh_q[SYNC_STAGES-1];
      end
   end

   assign rise = sh_q[SYNC_STAGES-1] & ~prev_q;
   assign fall = ~sh_q[SYNC_STAGES-1] & prev_q;
endmodule

// File: rtl/cap_channel.sv
module cap_channel
   import cap_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chan_cfg_t        cfg,
   input  logic             rise_ev,
   input  logic             fall_ev,
   input  logic [CNT_W-1:0] count,
   input  logic             clr_req,
   output logic [CNT_W-1:0] rise_q,
   output logic [CNT_W-1:0] fall_q,
   output logic             flag
);
   logic rise_cap, fall_cap, cap_any;

   assign rise_cap = cfg.cap_mode & cfg.rise_en & rise_ev;
   assign fall_cap = cfg.cap_mode & cfg.fall_en & fall_ev;
   assign cap_any  = rise_cap | fall_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_q <= '0;
         fall_q <= '0;
         flag   <= 1'b0;
      end else begin
         if (rise_cap) rise_q <= count;
         if (fall_cap) fall_q <= count;
         // a new capture outranks a clear on the same edge
         flag <= cap_any | (flag & ~clr_req);
      end
   end

   p_rise_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_cap |=> rise_q == $past(count));
   p_fall_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fall_cap |=> fall_q == $past(count));
   p_rise_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_cap |=> $stable(rise_q));
   p_fall_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_cap |=> $stable(fall_q));
   p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_any |=> flag);
   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !cap_any) |=> !flag);
   p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_req && !cap_any) |=> $stable(flag));
endmodule

// File: rtl/cap_latch_unit.sv
module cap_latch_unit
   import cap_pkg::*;
#(
   parameter int NCH         = 4,
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 8,
   parameter int REG_W       = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [NCH-1:0]    pwm_in,
   input  logic [NCH-1:0]    pad_in,
   output logic [NCH-1:0]    pad_out,
   output logic [NCH-1:0]    pad_oe,
   output logic              irq
);
   localparam int CTL_W    = NCH * CTL_BITS;
   localparam int REG_WORDS = OFS_LATCH + 2 * NCH;

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("NCH must be within 1..8");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (REG_W < CTL_W || REG_W < CNT_W || REG_W < PRE_W) begin : g_bad_regw
      $error("REG_W too narrow for a register field");
   end
   if ((1 << ADDR_W) < REG_WORDS) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [CTL_W-1:0] ctrl_q;
   logic [PRE_W-1:0] presc_q;
   logic [CNT_W-1:0] count;
   logic [NCH-1:0]   clr_vec, flag_vec, ie_vec;
   logic [CNT_W-1:0] rise_lat [NCH];
   logic [CNT_W-1:0] fall_lat [NCH];
   logic             wr_ctrl, wr_presc, wr_flag;

   assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
   assign wr_presc = reg_wr && (reg_addr == ADDR_W'(OFS_PRESC));
   assign wr_flag  = reg_wr && (reg_addr == ADDR_W'(OFS_FLAG));
   assign clr_vec  = wr_flag ? reg_wdata[NCH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         presc_q <= '0;
      end else begin
         if (wr_ctrl)  ctrl_q  <= reg_wdata[CTL_W-1:0];
         if (wr_presc) presc_q <= reg_wdata[PRE_W-1:0];
      end
   end

   cap_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tb (
      .clk   (clk),
      .rst_n (rst_n),
      .presc (presc_q),
      .count (count)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      chan_cfg_t cfg;
      logic      rise_ev, fall_ev;

      assign cfg       = chan_cfg_t'(ctrl_q[c*CTL_BITS +: CTL_BITS]);
      assign ie_vec[c] = cfg.irq_en;
      assign pad_oe[c] = ~cfg.cap_mode;
      assign pad_out[c] = cfg.cap_mode ? 1'b0 : pwm_in[c];

      cap_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (pad_in[c]),
         .rise  (rise_ev),
         .fall  (fall_ev)
      );

      cap_channel #(.CNT_W(CNT_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg     (cfg),
         .rise_ev (rise_ev),
         .fall_ev (fall_ev),
         .count   (count),
         .clr_req (clr_vec[c]),
         .rise_q  (rise_lat[c]),
         .fall_q  (fall_lat[c]),
         .flag    (flag_vec[c])
      );
   end

   assign irq = |(flag_vec & ie_vec);

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_CTRL))  reg_rdata[CTL_W-1:0] = ctrl_q;
      if (reg_addr == ADDR_W'(OFS_PRESC)) reg_rdata[PRE_W-1:0] = presc_q;
      if (reg_addr == ADDR_W'(OFS_FLAG))  reg_rdata[NCH-1:0]   = flag_vec;
      for (int c = 0; c < NCH; c++) begin
         if (reg_addr == ADDR_W'(OFS_LATCH + 2*c))     reg_rdata[CNT_W-1:0] = rise_lat[c];
         if (reg_addr == ADDR_W'(OFS_LATCH + 2*c + 1)) reg_rdata[CNT_W-1:0] = fall_lat[c];
      end
   end

   p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag_vec != '0));
   p_flag_clear_only_w1_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && reg_wdata[NCH-1:0] == '0) |=> (flag_vec & $past(flag_vec)) == $past(flag_vec));
endmodule

// File: tb/cap_latch_unit_test.sv
`timescale 1ns/1ps
module cap_latch_unit_test;
   localparam int NCH = 4;
   localparam int REG_W = 32;
   localparam int ADDR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic              reg_wr = 1'b0;
   logic [REG_W-1:0]  reg_wdata = '0;
   logic [REG_W-1:0]  reg_rdata;
   logic [NCH-1:0]    pwm_in = '0;
   logic [NCH-1:0]    pad_in = '0;
   logic [NCH-1:0]    pad_out, pad_oe;
   logic              irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cap_latch_unit #(.NCH(NCH), .REG_W(REG_W), .ADDR_W(ADDR_W)) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_in(pwm_in),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   // stimulus table: prescale, gap in clocks between edges, expected latch difference
   localparam int VEC_N = 5;
   localparam int VEC_PRE  [VEC_N] = '{0, 0, 3, 3, 1};
   localparam int VEC_GAP  [VEC_N] = '{5, 17, 8, 20, 6};
   localparam int VEC_DIFF [VEC_N] = '{5, 17, 2, 5, 3};

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic reg_write(input int addr, input logic [31:0] data);
      @(negedge clk);
      reg_addr = ADDR_W'(addr); reg_wdata = data; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input int addr, output logic [31:0] data);
      @(negedge clk);
      reg_addr = ADDR_W'(addr);
      #1 data = reg_rdata;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, a, b;
      wait_clk(3);
      rst_n = 1'b1;
      pwm_in = 4'b1010;
      wait_clk(2);

      // R1 reset state
      reg_read(4, v); check("R1 rise latch", v, 0);
      reg_read(5, v); check("R1 fall latch", v, 0);
      reg_read(2, v); check("R1 flags", v, 0);
      check("R1 irq", {31'b0, irq}, 0);
      check("R1 pad_oe", {28'b0, pad_oe}, 32'hF);
      // R2 PWM passthrough and ignored edges
      check("R2 pad_out follows pwm", {28'b0, pad_out}, 32'hA);
      pad_in[0] = 1'b1; wait_clk(5);
      reg_read(2, v); check("R2 no capture in PWM mode", v, 0);
      pad_in[0] = 1'b0; wait_clk(5);

      // ch1 without irq enable, others fully enabled
      reg_write(0, 32'hFF7F);
      wait_clk(1);
      check("R2 pad released", {28'b0, pad_oe}, 0);
      check("R2 pad_out low", {28'b0, pad_out}, 0);

      // R4 latency: capture on third edge after pin change
      @(negedge clk) pad_in[0] = 1'b1;
      wait_clk(2);
      check("R4 not yet captured", {31'b0, irq}, 0);
      wait_clk(1);
      check("R4 captured on third edge", {31'b0, irq}, 1);
      pad_in[0] = 1'b0; wait_clk(5);

      // table of prescale/gap vectors (R3, R4, R6)
      for (int i = 0; i < VEC_N; i++) begin
         reg_write(1, VEC_PRE[i]);
         reg_write(2, 32'hF);
         reg_read(2, v); check("R7 cleared before vector", v, 0);
         @(negedge clk) pad_in[0] = 1'b1;
         wait_clk(VEC_GAP[i]);
         pad_in[0] = 1'b0;
         wait_clk(5);
         reg_read(4, a); reg_read(5, b);
         check("R3 latch difference", 32'((a[15:0] - b[15:0]) & 16'hFFFF), VEC_DIFF[i]);
         reg_read(2, v); check("R6 flag set by capture", v, 1);
      end
      reg_write(1, 0);

      // R7 write zero keeps, write one clears
      reg_write(2, 0);
      reg_read(2, v); check("R7 zero write ignored", v, 1);
      reg_write(2, 1);
      reg_read(2, v); check("R7 one write clears", v, 0);

      // R8 capture and clear on the same edge
      @(negedge clk) pad_in[0] = 1'b1;
      wait_clk(2);
      reg_addr = ADDR_W'(2); reg_wdata = 32'h1; reg_wr = 1'b1;
      @(negedge clk) reg_wr = 1'b0;
      reg_read(2, v); check("R8 set wins over clear", v, 1);
      pad_in[0] = 1'b0; wait_clk(5);
      reg_write(2, 32'hF);

      // R5 rising capture disabled on ch0
      reg_write(0, 32'hFF7D);
      reg_read(4, a);
      reg_read(5, b);
      @(negedge clk) pad_in[0] = 1'b1;
      wait_clk(5);
      reg_read(4, v); check("R5 rise latch untouched", v, a);
      reg_read(2, v); check("R5 no flag from disabled edge", v, 0);
      pad_in[0] = 1'b0; wait_clk(5);
      reg_read(2, v); check("R5 falling edge still captured", v, 1);
      reg_read(5, v); check("R5 fall latch moved", {31'b0, v != b}, 1);
      reg_write(2, 32'hF);

      // R9 / R11 channel 1 without interrupt enable
      reg_read(4, a);
      @(negedge clk) pad_in[1] = 1'b1;
      wait_clk(5);
      reg_read(2, v); check("R11 only ch1 flag", v, 2);
      reg_read(4, v); check("R11 ch0 latch unchanged", v, a);
      check("R9 irq masked", {31'b0, irq}, 0);
      reg_write(0, 32'hFFFD);
      wait_clk(1);
      check("R9 irq after enable", {31'b0, irq}, 1);
      pad_in[1] = 1'b0; wait_clk(5);
      reg_write(2, 32'hF);

      // R10 later capture overwrites while flag set
      @(negedge clk) pad_in[2] = 1'b1;
      wait_clk(6);
      pad_in[2] = 1'b0;
      wait_clk(6);
      pad_in[2] = 1'b1;
      wait_clk(5);
      reg_read(8, b);
      reg_read(9, v);
      a = 32'((v[15:0] + 16'd6) & 16'hFFFF);
      check("R10 rise latch overwritten", 32'((a[15:0] - b[15:0]) & 16'hFFFF), 12);
      reg_read(2, v); check("R10 flag still set", v, 4);
      pad_in[2] = 1'b0; wait_clk(5);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule